// File: doc/BRIEF.md
# DSP Data-RAM Address Generator

This block produces the 9-bit data-RAM address for every instruction of a small DSP core. The address is made of a bank bit and an 8-bit word offset. The decoder tells the block which of three address forms the current instruction uses:

- **Direct:** the low nine instruction bits are the address itself.
- **Pointer-indirect:** one of six 8-bit pointer registers is read and then optionally post-modified.
- **Short-form direct:** a 5-bit address built from two instruction bits, two status bits and the bank bit, reaching the lowest 16 words of either bank.

The post-modification can be a plain 8-bit increment. It can also be an increment or decrement that wraps inside a power-of-two window whose size comes from three status bits. In the windowed case only the low bits of the pointer move and the upper bits stay fixed. This lets a routine walk a circular buffer with no software bookkeeping.

A separate load port lets the datapath write any pointer. A load wins over an automatic update of the same pointer in the same cycle. The RAM, instruction decode and datapath are outside the block.

Top module: `dram_addr_gen`

## Requirements
- R1: After reset all six pointers read as zero.
- R2: When `mode` is not 2'b01 (2'b10 is direct, 2'b00 and 2'b11 are idle), `addr` equals `instr[8:0]` and no pointer changes.
- R3: When `mode` is 2'b01 (indirect) and `instr[1:0]` is 0, 1 or 2, `addr` is {`instr[8]`, pointer}. The pointer is number `instr[1:0]` of set `instr[8]`, and its value is the one before this cycle's update.
- R4: Indirect with `instr[3:2]` = 2'b00 leaves the selected pointer unchanged.
- R5: Indirect with `instr[3:2]` = 2'b01 adds one to the selected pointer at the clock edge, wrapping from 8'hFF to 8'h00.
- R6: Indirect with `instr[3:2]` = 2'b11 adds one to the low `loop_code` bits of the selected pointer, modulo 2^`loop_code`. The upper bits are left unchanged; for example, with code 5, 8'hA9 counts to 8'hBF and then wraps to 8'hA0.
- R7: Indirect with `instr[3:2]` = 2'b10 subtracts one modulo 2^`loop_code` in the same way; for example, with code 7, 8'h80 becomes 8'hFF.
- R8: With `loop_code` = 3'b000 the two windowed modes leave the pointer unchanged.
- R9: Indirect with `instr[1:0]` = 2'b11 gives the short-form address. MSB first, it is `instr[8]`, four zero bits, `sf_bits[1]`, `sf_bits[0]`, `instr[3]`, `instr[2]`. No pointer changes.
- R10: With `ld_en` high, pointer `ld_idx` of set `ld_set` takes `ld_val` at the clock edge; `ld_idx` = 2'b11 writes nothing. The load takes priority over an automatic update of the same pointer.
- R11: The two pointer sets are independent: an access or load in one set does not change the other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 9 | Low nine instruction bits |
| mode | input | 2 | Address form: 01 indirect, 10 direct, 00/11 idle |
| loop_code | input | 3 | Log2 of the circular window size |
| sf_bits | input | 2 | Status bits mixed into the short-form address |
| ld_en | input | 1 | Pointer load strobe |
| ld_set | input | 1 | Pointer set to load |
| ld_idx | input | 2 | Pointer index to load (0 to 2) |
| ld_val | input | 8 | Value to load |
| addr | output | 9 | Data-RAM address {bank, offset} |

## Verification
The temporal properties compare two back-to-back indirect accesses that use the same instruction and status bits. They assume no load hits in between, and the antecedents require exactly that, so the addresses of the two accesses show how the pointer was modified. The directed stimulus changes inputs only on the falling clock edge. It keeps `loop_code` steady through each windowed walk and always uses a pointer index of 0 to 2 for loads, except where the ignored index is under test.

// File: rtl/dram_addr_gen.sv
module dram_addr_gen #(
  parameter int PTR_W = 8,
  parameter int NPTR  = 3,
  parameter int LC_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W:0]   instr,
  input  logic [1:0]       mode,
  input  logic [LC_W-1:0]  loop_code,
  input  logic [1:0]       sf_bits,
  input  logic             ld_en,
  input  logic             ld_set,
  input  logic [1:0]       ld_idx,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W:0]   addr
);
  localparam logic [1:0] M_IND  = 2'b01;
  localparam logic [1:0] SF_SEL = 2'b11;
  localparam logic [1:0] OP_NOP = 2'b00;
  localparam logic [1:0] OP_INC = 2'b01;
  localparam logic [1:0] OP_DEC = 2'b10;

  logic [PTR_W-1:0] ptr [2][NPTR];
  logic [PTR_W-1:0] cur, nxt, mask, sf_off;
  logic [PTR_W:0]   wide_mask;

  wire       set    = instr[PTR_W];
  wire [1:0] sel    = instr[1:0];
  wire [1:0] op     = instr[3:2];
  wire       is_ind = (mode == M_IND);
  wire       is_sf  = is_ind && (sel == SF_SEL);

  always_comb begin
    cur = '0;
    for (int i = 0; i < NPTR; i++)
      if (sel == 2'(i)) cur = ptr[set][i];
  end

  assign wide_mask = ({{PTR_W{1'b0}}, 1'b1} << loop_code) - 1'b1;
  assign mask      = wide_mask[PTR_W-1:0];

  always_comb begin
    case (op)
      OP_NOP:  nxt = cur;
      OP_INC:  nxt = cur + 1'b1;
      OP_DEC:  nxt = (cur & ~mask) | ((cur - 1'b1) & mask);
      default: nxt = (cur & ~mask) | ((cur + 1'b1) & mask);
    endcase
  end

  assign sf_off = {{(PTR_W-4){1'b0}}, sf_bits, instr[3:2]};
  assign addr   = !is_ind ? instr : is_sf ? {set, sf_off} : {set, cur};

  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ptr[s][p] <= '0;
        else if (ld_en && ld_set == 1'(s) && ld_idx == 2'(p))
          ptr[s][p] <= ld_val;
        else if (is_ind && !is_sf && set == 1'(s) && sel == 2'(p))
          ptr[s][p] <= nxt;
      end
    end
  end
endmodule

// File: rtl/dram_addr_gen_chk.sv
module dram_addr_gen_chk #(
  parameter int PTR_W = 8,
  parameter int LC_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W:0]   instr,
  input logic [1:0]       mode,
  input logic [LC_W-1:0]  loop_code,
  input logic [1:0]       sf_bits,
  input logic             ld_en,
  input logic             ld_set,
  input logic [1:0]       ld_idx,
  input logic [PTR_W-1:0] ld_val,
  input logic [PTR_W:0]   addr
);
  wire ind_ptr = (mode == 2'b01) && (instr[1:0] != 2'b11);
  logic [PTR_W:0] wm;
  assign wm = ({{PTR_W{1'b0}}, 1'b1} << loop_code) - 1'b1;
  wire [PTR_W-1:0] hi_mask = ~wm[PTR_W-1:0];

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (addr == instr));

  assert_short_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && instr[1:0] == 2'b11) |->
      (addr[PTR_W] == instr[PTR_W] && addr[PTR_W-1:4] == '0 && addr[3:2] == sf_bits));

  assert_nop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_ptr && instr[3:2] == 2'b00 && !ld_en) ##1 (mode == 2'b01 && $stable(instr))
      |-> $stable(addr));

  assert_plain_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_ptr && instr[3:2] == 2'b01 && !ld_en) ##1 (mode == 2'b01 && $stable(instr))
      |-> addr[PTR_W-1:0] == $past(addr[PTR_W-1:0]) + 1'b1);

  assert_loop_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_ptr && instr[3] && !ld_en) ##1 (mode == 2'b01 && $stable(instr) && $stable(loop_code))
      |-> (addr[PTR_W-1:0] & hi_mask) == ($past(addr[PTR_W-1:0]) & hi_mask));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_idx != 2'b11) ##1
      (mode == 2'b01 && instr[PTR_W] == $past(ld_set) && instr[1:0] == $past(ld_idx))
      |-> addr[PTR_W-1:0] == $past(ld_val));
endmodule

bind dram_addr_gen dram_addr_gen_chk #(.PTR_W(PTR_W), .LC_W(LC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .mode(mode), .loop_code(loop_code),
  .sf_bits(sf_bits), .ld_en(ld_en), .ld_set(ld_set), .ld_idx(ld_idx),
  .ld_val(ld_val), .addr(addr));

// File: tb/dram_addr_gen_bench.sv
module dram_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [8:0] instr = '0;
  logic [1:0] mode = 2'b00;
  logic [2:0] loop_code = '0;
  logic [1:0] sf_bits = '0;
  logic       ld_en = 0, ld_set = 0;
  logic [1:0] ld_idx = '0;
  logic [7:0] ld_val = '0;
  logic [8:0] addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dram_addr_gen u_dram_addr_gen (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [1:0] m, logic [8:0] ins, logic [8:0] exp, string req);
    mode = m; instr = ins;
    #1 chk(req, addr, exp);
    @(negedge clk);
    mode = 2'b00;
  endtask

  task automatic peek(logic s, logic [1:0] idx, logic [7:0] exp, string req);
    access(2'b01, {s, 4'b0, 2'b00, idx}, {s, exp}, req);
  endtask

  task automatic load(logic s, logic [1:0] idx, logic [7:0] v);
    ld_en = 1; ld_set = s; ld_idx = idx; ld_val = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 3; p++) peek(1'(s), 2'(p), 8'h00, "R1 reset");
  endtask

  task automatic t_direct;
    access(2'b10, 9'h1A5, 9'h1A5, "R2 direct");
    access(2'b11, 9'h0C6, 9'h0C6, "R2 idle");
    peek(1, 1, 8'h00, "R2 no pointer change");
    peek(0, 2, 8'h00, "R2 no pointer change");
  endtask

  task automatic t_inc;
    load(0, 0, 8'hFE);
    access(2'b01, {1'b0, 4'b0, 2'b01, 2'b00}, 9'h0FE, "R3 pre-update address");
    peek(0, 0, 8'hFF, "R5 increment");
    access(2'b01, {1'b0, 4'b0, 2'b01, 2'b00}, 9'h0FF, "R3 pre-update address");
    peek(0, 0, 8'h00, "R5 8-bit wrap");
  endtask

  task automatic t_nop;
    load(0, 1, 8'h37);
    access(2'b01, {1'b0, 4'b0, 2'b00, 2'b01}, 9'h037, "R4 nop");
    access(2'b01, {1'b0, 4'b0, 2'b00, 2'b01}, 9'h037, "R4 nop hold");
  endtask

  task automatic t_loop_up;
    loop_code = 3'd5;
    load(1, 2, 8'hA9);
    for (int i = 0; i < 23; i++)
      access(2'b01, {1'b1, 4'b0, 2'b11, 2'b10}, {1'b1, 8'hA0 | 8'((9 + i) % 32)}, "R6 loop up");
    peek(1, 2, 8'hA0, "R6 wrap to window base");
  endtask

  task automatic t_loop_down;
    loop_code = 3'd3;
    load(0, 2, 8'h50);
    access(2'b01, {1'b0, 4'b0, 2'b10, 2'b10}, 9'h050, "R7 loop down");
    peek(0, 2, 8'h57, "R7 wrap down in window of 8");
    loop_code = 3'd7;
    load(0, 2, 8'h80);
    access(2'b01, {1'b0, 4'b0, 2'b10, 2'b10}, 9'h080, "R7 loop down");
    peek(0, 2, 8'hFF, "R7 window of 128");
  endtask

  task automatic t_loop_zero;
    loop_code = 3'd0;
    load(1, 0, 8'h33);
    access(2'b01, {1'b1, 4'b0, 2'b11, 2'b00}, 9'h133, "R8 code zero up");
    access(2'b01, {1'b1, 4'b0, 2'b10, 2'b00}, 9'h133, "R8 code zero down");
    peek(1, 0, 8'h33, "R8 unchanged");
  endtask

  task automatic t_short;
    sf_bits = 2'b10;
    access(2'b01, {1'b1, 4'b0, 2'b01, 2'b11}, 9'h109, "R9 short form");
    sf_bits = 2'b01;
    access(2'b01, {1'b0, 4'hF, 2'b10, 2'b11}, 9'h006, "R9 short form");
    peek(1, 0, 8'h33, "R9 no pointer change");
    peek(1, 2, 8'hA0, "R9 no pointer change");
  endtask

  task automatic t_prio;
    load(0, 0, 8'h10);
    ld_en = 1; ld_set = 0; ld_idx = 2'd0; ld_val = 8'h44;
    access(2'b01, {1'b0, 4'b0, 2'b01, 2'b00}, 9'h010, "R10 access during load");
    ld_en = 0;
    peek(0, 0, 8'h44, "R10 load wins");
    ld_en = 1; ld_set = 1; ld_idx = 2'd1; ld_val = 8'h5A;
    access(2'b01, {1'b0, 4'b0, 2'b01, 2'b00}, 9'h044, "R10 other pointer");
    ld_en = 0;
    peek(0, 0, 8'h45, "R10 update of other pointer kept");
    peek(1, 1, 8'h5A, "R10 load kept");
    load(0, 2'b11, 8'hEE);
    peek(0, 0, 8'h45, "R10 index 3 ignored");
    peek(0, 1, 8'h37, "R10 index 3 ignored");
    peek(0, 2, 8'hFF, "R10 index 3 ignored");
  endtask

  task automatic t_sets;
    load(0, 1, 8'h11);
    load(1, 1, 8'h22);
    access(2'b01, {1'b1, 4'b0, 2'b01, 2'b01}, 9'h122, "R11 set one");
    peek(0, 1, 8'h11, "R11 set zero untouched");
    peek(1, 1, 8'h23, "R11 set one updated");
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_inc();
    t_nop();
    t_loop_up();
    t_loop_down();
    t_loop_zero();
    t_short();
    t_prio();
    t_sets();
    report();
  end
endmodule